// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address for each beat of a four-beat burst. A base address is captured whenever either of two active-low address strobes is sampled low on a rising clock edge. The upper bits of that address are held for the whole burst. The low two bits come from a small beat counter, which an active-low advance input steps forward.

A static mode input chooses how the low bits move through the four beats. In linear order they count upward from the starting offset and wrap modulo four. In interleaved order they are the starting offset XOR-ed with the beat number. When advance is high the address is held, so a burst can pause. A strobe that arrives while a burst is in progress starts a new burst from the newly supplied address. A flag marks the fourth beat of the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `curAddr` is all zeros and `lastBeat` is 0.
- R2: When `strobeAN` is low at a rising edge, `curAddr` equals `baseAddr` after that edge, and the beat number restarts at 0.
- R3: When `strobeBN` is low at a rising edge, the load happens exactly as for `strobeAN`. Both strobes low together also load.
- R4: With both strobes high, `advanceN` low at an edge moves the burst to the next beat. `advanceN` high holds `curAddr` and `lastBeat` unchanged.
- R5: With `interleave` = 0 (linear order), the low two bits of `curAddr` at beat n are (start + n) mod 4, where start is the low two bits of the loaded base.
- R6: With `interleave` = 1 (interleaved order), the low two bits at beat n are start XOR n.
- R7: An advance from beat 3 wraps to beat 0, which returns the low bits to the starting offset.
- R8: Bits above the low two never change between loads, including when the low bits wrap. No carry goes into them.
- R9: A strobe during a burst restarts the burst from the new base. If a strobe and an advance fall in the same cycle, the load wins and the advance is ignored.
- R10: `lastBeat` is 1 exactly while the beat number is 3. It clears on the next load or on the wrap to beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobeAN | input | 1 | First address strobe, active low |
| strobeBN | input | 1 | Second address strobe, active low |
| advanceN | input | 1 | Step to the next beat, active low |
| interleave | input | 1 | Burst order: 1 selects interleaved, 0 selects linear |
| baseAddr | input | ADDR_W | Address captured on a strobe |
| curAddr | output | ADDR_W | Address of the current beat |
| lastBeat | output | 1 | High on the fourth beat of the burst |

## Verification
A load and an advance can fall in the same cycle. The strobe must win, and the beat number must return to 0 rather than step. The bench provokes this by holding advance low on the same edge where a strobe arrives in the middle of a burst, sometimes with both strobes low. The scoreboard expects the new base address with `lastBeat` low, and then expects the following beats to count from that base. Wrap and hold cycles are mixed into the same runs, so a stale count or a lost beat shows up as an address mismatch.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic load;   // capture a new base, restart at beat 0
    logic step;   // move to the next beat
  } burstCtrl_t;

  // Low-bit offset for beat n under the selected order.
  function automatic logic [1:0] beatOffset2(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       xorOrder);
    beatOffset2 = xorOrder ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       strobeAN,
  input  logic       strobeBN,
  input  logic       advanceN,
  output burstCtrl_t ctrl
);

  logic anyStrobe;

  always_comb begin
    anyStrobe = ~strobeAN | ~strobeBN;
    ctrl.load = anyStrobe;
    // A load masks an advance in the same cycle.
    ctrl.step = ~anyStrobe & ~advanceN;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtrl_t        ctrl,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastBeat
);

  localparam int UPPER_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_IDX = {BEAT_W{1'b1}};

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (ctrl.load) begin
      upperQ <= baseAddr[ADDR_W-1:BEAT_W];
      startQ <= baseAddr[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (ctrl.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  generate
    if (BEAT_W == 2) begin : g_two
      always_comb lowBits = beatOffset2(startQ, beatQ, interleave);
    end else begin : g_wide
      always_comb lowBits = interleave ? (startQ ^ beatQ) : (startQ + beatQ);
    end
  endgenerate

  always_comb begin
    curAddr  = {upperQ, lowBits};
    lastBeat = (beatQ == LAST_IDX);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeAN,
  input  logic              strobeBN,
  input  logic              advanceN,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastBeat
);

  burstCtrl_t ctrl;

  burst_ctrl i_ctrl (
    .strobeAN (strobeAN),
    .strobeBN (strobeBN),
    .advanceN (advanceN),
    .ctrl     (ctrl)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .interleave (interleave),
    .baseAddr   (baseAddr),
    .curAddr    (curAddr),
    .lastBeat   (lastBeat)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobeAN,
  input logic              strobeBN,
  input logic              advanceN,
  input logic              interleave,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic              lastBeat
);

  logic anyLoad;
  assign anyLoad = !strobeAN || !strobeBN;

  // R2 R3 R9: any strobe presents the new base on the next cycle
  assert_load_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> (curAddr == $past(baseAddr)) && !lastBeat);

  // R4: hold when nothing is requested
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!anyLoad && advanceN) |=>
      ((interleave != $past(interleave)) ||
       ($stable(curAddr) && $stable(lastBeat))));

  // R8: upper bits change only on a load
  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> curAddr[ADDR_W-1:BEAT_W] == $past(curAddr[ADDR_W-1:BEAT_W]));

  // R5: linear order increments the low bits
  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!anyLoad && !advanceN && !interleave) |=>
      (interleave ||
       curAddr[BEAT_W-1:0] == $past(curAddr[BEAT_W-1:0]) + 1'b1));

  // R10: the last beat ends on the next advance (wrap)
  assert_last_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !anyLoad && !advanceN) |=> !lastBeat);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (.*);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              strobeAN = 1'b1;
  logic              strobeBN = 1'b1;
  logic              advanceN = 1'b1;
  logic              interleave = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [ADDR_W-1:0] curAddr;
  logic              lastBeat;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [ADDR_W-1:0] expAddrQ[$];
  logic              expLastQ[$];
  string             expTagQ[$];

  // bench model state
  logic [ADDR_W-3:0] mUpper = '0;
  logic [1:0]        mStart = '0;
  int                mBeat = 0;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst_addr_gen (
    .clk(clk), .rstN(rstN), .strobeAN(strobeAN), .strobeBN(strobeBN),
    .advanceN(advanceN), .interleave(interleave), .baseAddr(baseAddr),
    .curAddr(curAddr), .lastBeat(lastBeat)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <5000", cycles);
      done = 1'b1;
      finishRun();
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input bit sa, input bit sb, input bit adv,
                       input bit mode, input logic [ADDR_W-1:0] base,
                       input string tag);
    logic [1:0] low;
    @(negedge clk);
    strobeAN = ~sa; strobeBN = ~sb; advanceN = ~adv;
    interleave = mode; baseAddr = base;
    if (sa || sb) begin
      mUpper = base[ADDR_W-1:2]; mStart = base[1:0]; mBeat = 0;
    end else if (adv) begin
      mBeat = (mBeat + 1) % 4;
    end
    low = mode ? (mStart ^ 2'(mBeat)) : 2'((int'(mStart) + mBeat) % 4);
    expAddrQ.push_back({mUpper, low});
    expLastQ.push_back(mBeat == 3);
    expTagQ.push_back(tag);
  endtask

  // Monitor: compares after each edge.
  always @(posedge clk) begin
    #2;
    if (expAddrQ.size() > 0) begin
      logic [ADDR_W-1:0] ea;
      logic              el;
      string             t;
      ea = expAddrQ.pop_front();
      el = expLastQ.pop_front();
      t  = expTagQ.pop_front();
      checks++;
      if (curAddr !== ea || lastBeat !== el) begin
        errors++;
        $display("FAIL %s: actual addr=%h last=%b expected addr=%h last=%b",
                 t, curAddr, lastBeat, ea, el);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (curAddr !== '0 || lastBeat !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual addr=%h last=%b expected addr=0 last=0", curAddr, lastBeat);
    end
    rstN = 1'b1;
    // R2 linear burst from strobe A, with pauses (R4) and wrap (R7)
    drive(1, 0, 0, 0, 18'h12345, "R2 load A");
    drive(0, 0, 1, 0, 18'h0, "R5 linear beat1");
    drive(0, 0, 0, 0, 18'h0, "R4 hold");
    drive(0, 0, 1, 0, 18'h0, "R5 linear beat2");
    drive(0, 0, 1, 0, 18'h0, "R10 linear beat3");
    drive(0, 0, 0, 0, 18'h0, "R4 hold last");
    drive(0, 0, 1, 0, 18'h0, "R7 wrap");
    // R3 strobe B, low bits wrap without carry (R8)
    drive(0, 1, 0, 0, 18'h3FFFE, "R3 load B");
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 0, 18'h0, "R8 upper held");
    // R6 interleaved from offset 3 and 1
    drive(1, 0, 0, 1, 18'h0ABC3, "R6 load");
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 18'h0, "R6 xor beat");
    drive(0, 1, 0, 1, 18'h15551, "R6 load 1");
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 18'h0, "R6 xor beat");
    // R9 mid-burst restart with advance in same cycle
    drive(1, 0, 0, 0, 18'h00102, "R9 first");
    drive(0, 0, 1, 0, 18'h0, "R9 step");
    drive(0, 0, 1, 0, 18'h0, "R9 step");
    drive(0, 0, 1, 0, 18'h0, "R10 last");
    drive(1, 0, 1, 0, 18'h2F0F1, "R9 restart over advance");
    drive(0, 0, 1, 0, 18'h0, "R9 after restart");
    drive(1, 1, 1, 1, 18'h3A5A6, "R3 both strobes");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 1, 18'h0, "R10 to last");
    drive(0, 1, 0, 1, 18'h00007, "R10 clear on load");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      finishRun();
    end
  end

endmodule